// File: doc/BRIEF.md
# Checked Configuration Block Writer

This block sits behind a serial slave front end and turns a bulk configuration write into one atomic update. The front end hands it three kinds of events: a frame start, a stop, and received bytes, each byte marked by a one-cycle valid strobe. The first byte after a start is a command. Two commands are accepted. Code 05h targets the live configuration. Code 03h targets the power-on defaults held in persistent storage.

After an accepted command the block takes in a fixed run of data bytes, which is 146 by default, at offsets 0 upward. It keeps them in a shadow buffer and keeps a running XOR over them. The byte after the last data byte is a check byte. The data reaches its target only when the check byte equals that XOR. The commit is a single-cycle pulse that presents the whole shadow buffer together with a flag that names the target.

A check byte that does not match, or a stop or restart before the check byte, leaves the target untouched. Every byte the block processes gets an ACK or NAK answer one cycle later. The outcome of the last block is shown on separate pass and fail flags.

Top module: `cfg_blk_writer`

## Requirements
- R1: While reset is asserted and after it is released, ackValid, commitPulse, passFlag and failFlag are 0.
- R2: The first byte after frameStart is a command. 03h and 05h are ACKed. Any other value is NAKed, and every later byte of that frame is NAKed with no commit.
- R3: Each of the DATA_BYTES data bytes that follow an accepted command is ACKed. Every processed byte gets ackValid=1 in the cycle after its byteValid.
- R4: A check byte equal to the XOR of all data bytes is ACKed. In the same cycle as that ACK, commitPulse is high for exactly one cycle and passFlag becomes 1.
- R5: During commitPulse, commitLive is 1 for command 05h and 0 for command 03h. commitData bits [8k+7:8k] hold the data byte received at offset k.
- R6: A check byte that differs from the XOR is NAKed and sets failFlag. No commit is made.
- R7: A frameStop after an accepted command but before the check byte sets failFlag. It makes no commit and produces no ACK or NAK answer.
- R8: Bytes after the check byte in the same frame are NAKed. They cause no commit and leave passFlag and failFlag unchanged.
- R9: frameStart clears passFlag and failFlag. A block in progress is dropped without a commit, and the next byte is taken as a new command.
- R10: A byte that arrives outside a frame, after a stop or before any start, is NAKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Start condition seen by the front end (wins over the others in the same cycle) |
| frameStop | input | 1 | Stop condition seen by the front end (wins over a byte) |
| byteValid | input | 1 | One-cycle strobe: byteData holds a received byte |
| byteData | input | 8 | Received byte |
| ackValid | output | 1 | An ACK/NAK answer is present this cycle |
| ackOk | output | 1 | 1 = ACK, 0 = NAK; meaningful while ackValid is high |
| commitPulse | output | 1 | One-cycle commit of the shadow buffer |
| commitLive | output | 1 | Target of the commit: 1 live configuration, 0 power-on defaults |
| commitData | output | DATA_BYTES*8 | Shadow buffer, byte k at bits [8k+7:8k] |
| passFlag | output | 1 | Last block passed its check |
| failFlag | output | 1 | Last block failed its check or was cut short |

## Verification
Full blocks are sent for both commands with a ramp-like pattern, an all-zero pattern and an all-FFh pattern. The ramp-like pattern shows whether bytes land at their own offset and whether the target flag follows the command. The zero and FFh patterns both give a check byte of 00h, so they test whether the comparison really depends on the data and not on a default value. Further frames cover a corrupted check byte, a stop after 50 bytes, a restart in the middle of a block, an unknown command, extra bytes after the check, and bytes sent with no frame open. Each of these should give NAKs and no commit, and each sets the flags in its own way.

// File: rtl/cfg_blk_pkg.sv
package cfg_blk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_DONE,
    ST_REJECT
  } ctrlState_t;

  typedef struct packed {
    logic clrAcc;
    logic wrByte;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_blk_dpath.sv
module cfg_blk_dpath
  import cfg_blk_pkg::*;
#(
  parameter int DATA_BYTES = 146,
  localparam int CW = $clog2(DATA_BYTES + 1),
  localparam int DW = DATA_BYTES * 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [CW-1:0] wrIndex,
  input  logic [7:0]    byteData,
  output logic          chkMatch,
  output logic [DW-1:0] commitData
);

  logic [7:0] xorAcc;
  logic [7:0] shadow [DATA_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xorAcc <= 8'h00;
    end else if (strobe.clrAcc) begin
      xorAcc <= 8'h00;
    end else if (strobe.wrByte) begin
      xorAcc <= xorAcc ^ byteData;
    end
  end

  assign chkMatch = (xorAcc == byteData);

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadow[g] <= 8'h00;
      end else if (strobe.wrByte && (wrIndex == CW'(g))) begin
        shadow[g] <= byteData;
      end
    end
    assign commitData[g*8 +: 8] = shadow[g];
  end

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrByte |=> $stable(commitData));

  // R3
  acc_fold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrByte && !strobe.clrAcc) |=> (xorAcc == ($past(xorAcc) ^ $past(byteData))));

endmodule

// File: rtl/cfg_blk_ctrl.sv
module cfg_blk_ctrl
  import cfg_blk_pkg::*;
#(
  parameter int         DATA_BYTES   = 146,
  parameter logic [7:0] CMD_DEFAULTS = 8'h03,
  parameter logic [7:0] CMD_LIVE     = 8'h05,
  localparam int CW = $clog2(DATA_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          frameStop,
  input  logic          byteValid,
  input  logic [7:0]    byteData,
  input  logic          chkMatch,
  output dpStrobe_t     strobe,
  output logic [CW-1:0] wrIndex,
  output logic          ackValid,
  output logic          ackOk,
  output logic          commitPulse,
  output logic          commitLive,
  output logic          passFlag,
  output logic          failFlag
);

  localparam logic [CW-1:0] LAST_IDX = CW'(DATA_BYTES);

  ctrlState_t    state;
  logic [CW-1:0] byteCnt;
  logic          byteTake;
  logic          cmdOk;
  logic          dataSlot;
  logic          checkSlot;

  assign byteTake  = byteValid && !frameStart && !frameStop;
  assign cmdOk     = (byteData == CMD_DEFAULTS) || (byteData == CMD_LIVE);
  assign dataSlot  = byteTake && (state == ST_DATA) && (byteCnt < LAST_IDX);
  assign checkSlot = byteTake && (state == ST_DATA) && (byteCnt == LAST_IDX);

  always_comb begin
    strobe        = '0;
    strobe.clrAcc = byteTake && (state == ST_CMD) && cmdOk;
    strobe.wrByte = dataSlot;
  end

  assign wrIndex = byteCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      byteCnt     <= '0;
      ackValid    <= 1'b0;
      ackOk       <= 1'b0;
      commitPulse <= 1'b0;
      commitLive  <= 1'b0;
      passFlag    <= 1'b0;
      failFlag    <= 1'b0;
    end else begin
      ackValid    <= 1'b0;
      commitPulse <= 1'b0;
      if (frameStart) begin
        state    <= ST_CMD;
        byteCnt  <= '0;
        passFlag <= 1'b0;
        failFlag <= 1'b0;
      end else if (frameStop) begin
        if (state == ST_DATA) failFlag <= 1'b1;
        state <= ST_IDLE;
      end else if (byteValid) begin
        ackValid <= 1'b1;
        ackOk    <= 1'b0;
        unique case (state)
          ST_CMD: begin
            if (cmdOk) begin
              ackOk      <= 1'b1;
              commitLive <= (byteData == CMD_LIVE);
              byteCnt    <= '0;
              state      <= ST_DATA;
            end else begin
              state <= ST_REJECT;
            end
          end
          ST_DATA: begin
            if (byteCnt < LAST_IDX) begin
              ackOk   <= 1'b1;
              byteCnt <= byteCnt + CW'(1);
            end else begin
              state <= ST_DONE;
              if (chkMatch) begin
                ackOk       <= 1'b1;
                commitPulse <= 1'b1;
                passFlag    <= 1'b1;
              end else begin
                failFlag <= 1'b1;
              end
            end
          end
          default: ackOk <= 1'b0;
        endcase
      end
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LAST_IDX);

  // R4
  commit_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> (ackValid && ackOk && passFlag));

  // R4
  commit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  // R6
  nak_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !ackOk) |-> !commitPulse);

  // R6
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(passFlag && failFlag));

  // R8
  done_nak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteTake && (state == ST_DONE)) |=> (ackValid && !ackOk && $stable(passFlag) && $stable(failFlag)));

  // R10
  idle_nak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteTake && (state == ST_IDLE)) |=> (ackValid && !ackOk));

  // R2
  reject_nak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteTake && (state == ST_REJECT)) |=> (ackValid && !ackOk));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (!passFlag && !failFlag && !commitPulse));

endmodule

// File: rtl/cfg_blk_writer.sv
module cfg_blk_writer
  import cfg_blk_pkg::*;
#(
  parameter int         DATA_BYTES   = 146,
  parameter logic [7:0] CMD_DEFAULTS = 8'h03,
  parameter logic [7:0] CMD_LIVE     = 8'h05
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameStart,
  input  logic                    frameStop,
  input  logic                    byteValid,
  input  logic [7:0]              byteData,
  output logic                    ackValid,
  output logic                    ackOk,
  output logic                    commitPulse,
  output logic                    commitLive,
  output logic [DATA_BYTES*8-1:0] commitData,
  output logic                    passFlag,
  output logic                    failFlag
);

  localparam int CW = $clog2(DATA_BYTES + 1);

  dpStrobe_t     strobe;
  logic [CW-1:0] wrIndex;
  logic          chkMatch;

  cfg_blk_ctrl #(
    .DATA_BYTES  (DATA_BYTES),
    .CMD_DEFAULTS(CMD_DEFAULTS),
    .CMD_LIVE    (CMD_LIVE)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .frameStop  (frameStop),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .chkMatch   (chkMatch),
    .strobe     (strobe),
    .wrIndex    (wrIndex),
    .ackValid   (ackValid),
    .ackOk      (ackOk),
    .commitPulse(commitPulse),
    .commitLive (commitLive),
    .passFlag   (passFlag),
    .failFlag   (failFlag)
  );

  cfg_blk_dpath #(
    .DATA_BYTES(DATA_BYTES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrIndex   (wrIndex),
    .byteData  (byteData),
    .chkMatch  (chkMatch),
    .commitData(commitData)
  );

endmodule

// File: tb/sim_cfg_blk_writer.sv
module sim_cfg_blk_writer;

  localparam int NB = 146;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic frameStop = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic ackValid, ackOk, commitPulse, commitLive, passFlag, failFlag;
  logic [NB*8-1:0] commitData;

  always #4 clk = ~clk;

  cfg_blk_writer u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameStop(frameStop),
    .byteValid(byteValid), .byteData(byteData), .ackValid(ackValid), .ackOk(ackOk),
    .commitPulse(commitPulse), .commitLive(commitLive), .commitData(commitData),
    .passFlag(passFlag), .failFlag(failFlag)
  );

  int errors = 0;
  int checks = 0;
  int commitSeen = 0;
  bit armed = 1'b0;
  bit finished = 1'b0;

  // behavioural reference: 0 idle, 1 await command, 2 collecting, 3 finished block, 4 rejected
  int mMode = 0;
  logic [7:0] mXor = 8'h00;
  logic [7:0] mBuf[$];
  logic eAckValid = 1'b0, eAckOk = 1'b0, eCommit = 1'b0;
  logic ePass = 1'b0, eFail = 1'b0, eLive = 1'b0;
  string eTag = "R1";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    armed <= 1'b1;
    eAckValid = 1'b0;
    eCommit = 1'b0;
    if (!rstN) begin
      mMode = 0; ePass = 1'b0; eFail = 1'b0; eTag = "R1";
    end else if (frameStart) begin
      mMode = 1; ePass = 1'b0; eFail = 1'b0; eTag = "R9";
    end else if (frameStop) begin
      if (mMode == 2) eFail = 1'b1;
      mMode = 0; eTag = "R7";
    end else if (byteValid) begin
      eAckValid = 1'b1;
      eAckOk = 1'b0;
      case (mMode)
        1: begin
          eTag = "R2";
          if (byteData == 8'h03 || byteData == 8'h05) begin
            eAckOk = 1'b1; eLive = (byteData == 8'h05);
            mBuf.delete(); mXor = 8'h00; mMode = 2;
          end else mMode = 4;
        end
        2: begin
          if (mBuf.size() < NB) begin
            eTag = "R3"; eAckOk = 1'b1;
            mBuf.push_back(byteData); mXor = mXor ^ byteData;
          end else begin
            mMode = 3;
            if (byteData == mXor) begin
              eTag = "R4"; eAckOk = 1'b1; eCommit = 1'b1; ePass = 1'b1;
            end else begin
              eTag = "R6"; eFail = 1'b1;
            end
          end
        end
        3: eTag = "R8";
        4: eTag = "R2";
        default: eTag = "R10";
      endcase
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      chk(ackValid === eAckValid, eTag, "ackValid", ackValid, eAckValid);
      if (eAckValid) chk(ackOk === eAckOk, eTag, "ackOk", ackOk, eAckOk);
      chk(commitPulse === eCommit, eTag, "commitPulse", commitPulse, eCommit);
      chk(passFlag === ePass, "R4", "passFlag", passFlag, ePass);
      chk(failFlag === eFail, "R6", "failFlag", failFlag, eFail);
      if (commitPulse) commitSeen++;
      if (eCommit && commitPulse) begin
        int bad;
        bad = -1;
        chk(commitLive === eLive, "R5", "commitLive", commitLive, eLive);
        for (int k = 0; k < NB; k++)
          if (bad < 0 && commitData[k*8 +: 8] !== mBuf[k]) bad = k;
        if (bad < 0) chk(1'b1, "R5", "commitData", 0, 0);
        else chk(1'b0, "R5", "commitData byte", int'(commitData[bad*8 +: 8]), int'(mBuf[bad]));
      end
    end
  end

  function automatic logic [7:0] gen(input int seed, input int i);
    if (seed == 0) return 8'h00;
    if (seed == 1) return 8'hff;
    return 8'((i * seed) + ((i >> 2) * 13) + seed);
  endfunction

  task automatic drv(input bit s, input bit p, input bit v, input logic [7:0] d);
    @(negedge clk);
    frameStart = s; frameStop = p; byteValid = v; byteData = d;
  endtask

  task automatic frame(input logic [7:0] cmd, input int n, input int seed,
                       input bit corrupt, input int extra, input bit stop);
    logic [7:0] x;
    x = 8'h00;
    drv(1, 0, 0, 8'h00);
    drv(0, 0, 1, cmd);
    for (int i = 0; i < n; i++) begin
      x = x ^ gen(seed, i);
      drv(0, 0, 1, gen(seed, i));
    end
    if (n == NB) drv(0, 0, 1, corrupt ? (x ^ 8'h5a) : x);
    for (int e = 0; e < extra; e++) drv(0, 0, 1, 8'hee);
    if (stop) drv(0, 1, 0, 8'h00);
    drv(0, 0, 0, 8'h00);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed at the ports
    chk(ackValid === 1'b0 && commitPulse === 1'b0 && passFlag === 1'b0 && failFlag === 1'b0,
        "R1", "reset outputs", {ackValid, commitPulse, passFlag, failFlag}, 0);
    rstN = 1'b1;
    drv(0, 0, 0, 8'h00);
    // R10: byte before any frame
    drv(0, 0, 1, 8'h03);
    drv(0, 0, 0, 8'h00);
    // R4 R5: good live write, then good defaults write with extra bytes (R8)
    frame(8'h05, NB, 7, 0, 0, 1);
    chk(commitSeen == 1, "R4", "commit count live", commitSeen, 1);
    frame(8'h03, NB, 29, 0, 2, 1);
    chk(commitSeen == 2, "R8", "commit count defaults+extra", commitSeen, 2);
    // R6: corrupted check byte
    frame(8'h05, NB, 11, 1, 1, 1);
    chk(commitSeen == 2 && failFlag === 1'b1, "R6", "bad check no commit", commitSeen, 2);
    // R7: short block
    frame(8'h03, 50, 5, 0, 0, 1);
    chk(commitSeen == 2 && failFlag === 1'b1, "R7", "short block no commit", commitSeen, 2);
    // R2: unknown command
    frame(8'h04, NB, 3, 0, 0, 1);
    chk(commitSeen == 2 && failFlag === 1'b0, "R2", "unknown command", commitSeen, 2);
    // R10: stray byte after stop
    drv(0, 0, 1, 8'h05);
    drv(0, 0, 0, 8'h00);
    // R9: restart mid-block, then all-zero live block
    drv(1, 0, 0, 8'h00);
    drv(0, 0, 1, 8'h05);
    for (int i = 0; i < 20; i++) drv(0, 0, 1, gen(9, i));
    frame(8'h05, NB, 0, 0, 0, 1);
    chk(commitSeen == 3, "R9", "restart then commit", commitSeen, 3);
    // R4: all-FF defaults block (check 00h)
    frame(8'h03, NB, 1, 0, 0, 1);
    chk(commitSeen == 4 && passFlag === 1'b1, "R4", "all-ones block", commitSeen, 4);
    // R2: stop right after start, nothing committed
    frame(8'h42, 0, 0, 0, 0, 1);
    chk(commitSeen == 4, "R2", "empty frame", commitSeen, 4);
    repeat (3) drv(0, 0, 0, 8'h00);
    finish_run();
  end

endmodule